// File: doc/BRIEF.md
# Paged RAM Address Generator

This block turns the short memory operand field of a compact instruction word into a full word address for a single-port, 32-bit wide RAM. The RAM is organised as 256-bit rows of eight words each. Instructions reach memory through a page register: one page spans four consecutive rows. An operand therefore needs only five bits. Two bits choose a row inside the current page and three bits choose a word inside that row.

The page register is managed by three page instructions. One loads an immediate value, one moves to the next page and one moves to the previous page. Each access presents a valid strobe, a write flag and the operand. The block answers in the same cycle with the physical word address and a read or write strobe toward the RAM.

The default RAM holds nine rows (2304 bits). The page register is three bits wide, so an operand can point at a row that does not exist. Such an access raises an out-of-range flag and issues no strobe.

Top module: `paged_addr_gen`

## Requirements
- R1: After reset the page register holds 0, so an access with operand 0 produces word address 0.
- R2: The operand's bits [4:3] select the row inside the page and bits [2:0] select the word. The word address is (page*4 + row)*8 + word, valid in the same cycle as the access.
- R3: pageOp = 1 (select) loads the page register with pageImm. The new page applies from the next cycle.
- R4: pageOp = 2 (increment) adds one to the page register from the next cycle, wrapping from 7 to 0.
- R5: pageOp = 3 (decrement) subtracts one from the page register from the next cycle, wrapping from 0 to 7.
- R6: An access issued in the same cycle as a page instruction uses the page held before that instruction.
- R7: A valid in-range access raises ramRead when accWrite is 0 and ramWrite when accWrite is 1. It never raises both.
- R8: A valid access whose computed row (page*4 + row) is 9 or more raises outOfRange and raises neither ramRead nor ramWrite.
- R9: With accValid low, ramRead, ramWrite and outOfRange are all low, whatever the operand.
- R10: pageOp = 0 leaves the page register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| pageOp | input | 2 | Page instruction: 0 none, 1 select, 2 increment, 3 decrement |
| pageImm | input | 3 | Immediate page number for select |
| accValid | input | 1 | A memory access is requested this cycle |
| accWrite | input | 1 | Access is a write (1) or a read (0) |
| operand | input | 5 | Operand field: row in [4:3], word in [2:0] |
| ramAddr | output | 8 | Physical word address |
| ramRead | output | 1 | Read strobe toward the RAM |
| ramWrite | output | 1 | Write strobe toward the RAM |
| outOfRange | output | 1 | Valid access targets a row beyond the RAM |

## Verification
The address, the strobes and the range flag are combinational from the access inputs and the current page, so they are due in the same cycle. The bench drives inputs on the falling edge and samples one nanosecond later, before the next rising edge. A page instruction takes effect at the following rising edge. Its result is therefore checked on the access issued in the next cycle, while an access paired with the instruction itself is checked against the old page. Every page value is set by select and swept across all 32 operands for both reads and writes, with the expected address and range computed arithmetically.

// File: rtl/paged_addr_pkg.sv
package paged_addr_pkg;

  typedef enum logic [1:0] {
    PG_HOLD = 2'd0,
    PG_LOAD = 2'd1,
    PG_INC  = 2'd2,
    PG_DEC  = 2'd3
  } pageOp_e;

  typedef struct packed {
    logic loadPage;
    logic incPage;
    logic decPage;
  } pageCtrl_t;

endpackage

// File: rtl/paged_addr_ctrl.sv
module paged_addr_ctrl
  import paged_addr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pageOp,
  input  logic       accValid,
  input  logic       accWrite,
  input  logic       inRange,
  output pageCtrl_t  ctrl,
  output logic       ramRead,
  output logic       ramWrite,
  output logic       outOfRange
);

  pageOp_e opCode;

  always_comb begin
    opCode = pageOp_e'(pageOp);
    ctrl = '0;
    unique case (opCode)
      PG_LOAD: ctrl.loadPage = 1'b1;
      PG_INC:  ctrl.incPage  = 1'b1;
      PG_DEC:  ctrl.decPage  = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    ramRead    = accValid && !accWrite && inRange;
    ramWrite   = accValid && accWrite && inRange;
    outOfRange = accValid && !inRange;
  end

  // R8: an out-of-range access never reaches the RAM
  p_no_strobe_oor_r8: assert property (@(posedge clk) disable iff (!rstN)
    outOfRange |-> (!ramRead && !ramWrite));

  // R7: read and write strobes never coincide
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(ramRead && ramWrite));

  // R9: idle cycles are quiet
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (!ramRead && !ramWrite && !outOfRange));

  // page strobes are mutually exclusive
  p_one_page_op_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.loadPage, ctrl.incPage, ctrl.decPage}));

endmodule

// File: rtl/paged_addr_dp.sv
module paged_addr_dp
  import paged_addr_pkg::*;
#(
  parameter int PAGE_W        = 3,
  parameter int ROWS_PER_PAGE = 4,
  parameter int ROW_BITS      = 256,
  parameter int WORD_BITS     = 32,
  parameter int NUM_ROWS      = 9,
  localparam int ROWSEL_W     = $clog2(ROWS_PER_PAGE),
  localparam int WORDS_PER_ROW = ROW_BITS / WORD_BITS,
  localparam int WORDSEL_W    = $clog2(WORDS_PER_ROW),
  localparam int OPND_W       = ROWSEL_W + WORDSEL_W,
  localparam int ROW_IDX_W    = PAGE_W + ROWSEL_W,
  localparam int ADDR_W       = ROW_IDX_W + WORDSEL_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  pageCtrl_t         ctrl,
  input  logic [PAGE_W-1:0] pageImm,
  input  logic [OPND_W-1:0] operand,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              inRange
);

  logic [PAGE_W-1:0]    curPage;
  logic [ROWSEL_W-1:0]  rowSel;
  logic [WORDSEL_W-1:0] wordSel;
  logic [ROW_IDX_W-1:0] rowIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPage <= '0;
    end else if (ctrl.loadPage) begin
      curPage <= pageImm;
    end else if (ctrl.incPage) begin
      curPage <= curPage + PAGE_W'(1);
    end else if (ctrl.decPage) begin
      curPage <= curPage - PAGE_W'(1);
    end
  end

  always_comb begin
    rowSel  = operand[OPND_W-1:WORDSEL_W];
    wordSel = operand[WORDSEL_W-1:0];
    rowIdx  = ROW_IDX_W'(curPage) * ROW_IDX_W'(ROWS_PER_PAGE) + ROW_IDX_W'(rowSel);
    ramAddr = ADDR_W'(rowIdx) * ADDR_W'(WORDS_PER_ROW) + ADDR_W'(wordSel);
    inRange = (32'(rowIdx) < 32'(NUM_ROWS));
  end

  // R3: select loads the immediate
  p_page_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadPage |=> (curPage == $past(pageImm)));

  // R4: increment moves one page up, modulo the register width
  p_page_inc_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.incPage |=> (curPage == $past(curPage) + PAGE_W'(1)));

  // R5: decrement moves one page down, modulo the register width
  p_page_dec_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.decPage |=> (curPage == $past(curPage) - PAGE_W'(1)));

  // R10: no page instruction keeps the page
  p_page_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.loadPage || ctrl.incPage || ctrl.decPage) |=> $stable(curPage));

endmodule

// File: rtl/paged_addr_gen.sv
module paged_addr_gen
  import paged_addr_pkg::*;
#(
  parameter int PAGE_W        = 3,
  parameter int ROWS_PER_PAGE = 4,
  parameter int ROW_BITS      = 256,
  parameter int WORD_BITS     = 32,
  parameter int NUM_ROWS      = 9,
  localparam int OPND_W       = $clog2(ROWS_PER_PAGE) + $clog2(ROW_BITS / WORD_BITS),
  localparam int ADDR_W       = PAGE_W + OPND_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        pageOp,
  input  logic [PAGE_W-1:0] pageImm,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [OPND_W-1:0] operand,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramRead,
  output logic              ramWrite,
  output logic              outOfRange
);

  pageCtrl_t ctrl;
  logic      inRange;

  paged_addr_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .pageOp     (pageOp),
    .accValid   (accValid),
    .accWrite   (accWrite),
    .inRange    (inRange),
    .ctrl       (ctrl),
    .ramRead    (ramRead),
    .ramWrite   (ramWrite),
    .outOfRange (outOfRange)
  );

  paged_addr_dp #(
    .PAGE_W        (PAGE_W),
    .ROWS_PER_PAGE (ROWS_PER_PAGE),
    .ROW_BITS      (ROW_BITS),
    .WORD_BITS     (WORD_BITS),
    .NUM_ROWS      (NUM_ROWS)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .pageImm (pageImm),
    .operand (operand),
    .ramAddr (ramAddr),
    .inRange (inRange)
  );

endmodule

// File: tb/paged_addr_gen_tb_top.sv
`timescale 1ns/1ps
module paged_addr_gen_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] pageOp = 2'd0;
  logic [2:0] pageImm = 3'd0;
  logic       accValid = 1'b0;
  logic       accWrite = 1'b0;
  logic [4:0] operand = 5'd0;
  logic [7:0] ramAddr;
  logic       ramRead;
  logic       ramWrite;
  logic       outOfRange;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  paged_addr_gen dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .pageOp     (pageOp),
    .pageImm    (pageImm),
    .accValid   (accValid),
    .accWrite   (accWrite),
    .operand    (operand),
    .ramAddr    (ramAddr),
    .ramRead    (ramRead),
    .ramWrite   (ramWrite),
    .outOfRange (outOfRange)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one access this cycle, optionally with a page op; checks against expPage
  task automatic access(string req, int expPage, int opnd, bit wr, bit valid, int op, int imm);
    int row;
    int expAddr;
    bit inR;
    @(negedge clk);
    pageOp   = 2'(op);
    pageImm  = 3'(imm);
    accValid = valid;
    accWrite = wr;
    operand  = 5'(opnd);
    #1;
    row     = expPage * 4 + (opnd >> 3);
    expAddr = row * 8 + (opnd & 7);
    inR     = (row < 9);
    chk(req, "ramAddr", int'(ramAddr), expAddr);
    chk(req, "ramRead", int'(ramRead), int'(valid && !wr && inR));
    chk(req, "ramWrite", int'(ramWrite), int'(valid && wr && inR));
    chk(req, "outOfRange", int'(outOfRange), int'(valid && !inR));
  endtask

  task automatic pageCmd(int op, int imm);
    @(negedge clk);
    pageOp   = 2'(op);
    pageImm  = 3'(imm);
    accValid = 1'b0;
    @(negedge clk);
    pageOp = 2'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset page is 0
    access("R1", 0, 0, 1'b0, 1'b1, 0, 0);
    access("R1", 0, 31, 1'b1, 1'b1, 0, 0);

    // R2 R3 R7 R8: every page, every operand, read and write
    for (int p = 0; p < 8; p++) begin
      pageCmd(1, p);
      access("R3", p, 0, 1'b0, 1'b1, 0, 0);
      for (int o = 0; o < 32; o++) begin
        for (int w = 0; w < 2; w++) begin
          access(((p * 4 + (o >> 3)) >= 9) ? "R8" : (w ? "R7" : "R2"), p, o, w[0], 1'b1, 0, 0);
        end
      end
    end

    // R4: increment with wrap from 7 to 0
    pageCmd(1, 6);
    pageCmd(2, 0);
    access("R4", 7, 5, 1'b0, 1'b1, 0, 0);
    pageCmd(2, 0);
    access("R4", 0, 5, 1'b1, 1'b1, 0, 0);

    // R5: decrement with wrap from 0 to 7
    pageCmd(3, 0);
    access("R5", 7, 0, 1'b1, 1'b1, 0, 0);
    pageCmd(1, 2);
    pageCmd(3, 0);
    access("R5", 1, 9, 1'b0, 1'b1, 0, 0);

    // R6: access paired with a page op sees the old page
    access("R6", 1, 12, 1'b0, 1'b1, 2, 0);
    access("R6", 2, 2, 1'b1, 1'b1, 1, 5);
    access("R6", 5, 3, 1'b0, 1'b1, 3, 0);
    access("R6", 4, 3, 1'b0, 1'b1, 0, 0);

    // R10: hold for several cycles, page stays 4
    for (int i = 0; i < 4; i++) access("R10", 4, i * 7, 1'b0, 1'b0, 0, 3);
    access("R10", 4, 1, 1'b1, 1'b1, 0, 0);

    // R9: idle accesses, in range and out of range
    pageCmd(1, 0);
    access("R9", 0, 4, 1'b0, 1'b0, 0, 0);
    access("R9", 0, 17, 1'b1, 1'b0, 0, 0);
    pageCmd(1, 7);
    access("R9", 7, 31, 1'b1, 1'b0, 0, 0);
    access("R9", 7, 31, 1'b0, 1'b0, 0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule